// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This unit keeps the three program-counter values that a 32-bit core with architectural branch delay slots needs. These are the address being fetched now, the address after it, and the address after that. Each clock it takes one decoded control-flow command together with its operands and moves the three addresses forward. The instruction that follows a branch or jump (the delay slot) therefore always executes before the destination, with one exception. A likely-form branch that is not taken skips its slot.

The same command also produces two kinds of side output. A link write carries the return address to a register index. Clear strobes tell the status logic to drop its error-level, exception-level, load-linked and debug-exception bits. Instruction decode, the register file, branch-condition evaluation and exception entry live elsewhere. Their results arrive here as plain inputs.

Top module: `dspc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the three addresses load RESET_VEC, RESET_VEC+4 and RESET_VEC+8. No link write or clear strobe is raised while `rst` is high.
- R2: While `stall_i` is high, all three addresses keep their values at the edge. `link_we_o`, every clear strobe and `unsupported_o` stay low.
- R3: `cmd_i` is coded as follows: 0 step, 1 conditional branch, 2 absolute jump, 3 register jump, 4 exception return, 5 debug return. Codes 6 and 7 behave as a step. A step makes the fetch address the old next address and the next address the old next-next address. The next-next address becomes the old next-next plus 4.
- R4: A branch with `taken_i` high goes first to the delay slot, so the new fetch address is the old next address. The new next address is the old next address plus `disp_i`, and the new next-next address is that target plus 4.
- R5: A branch with `taken_i` low steps once when `likely_i` is low. When `likely_i` is high it steps twice: the fetch address becomes the old next-next address and the delay slot is annulled.
- R6: An absolute jump executes the delay slot. Its target keeps the top 4 bits of the old next address, places `jtarg_i` in bits 27:2 and zeroes bits 1:0. The new next-next address is the target plus 4.
- R7: A register jump executes the delay slot, then goes to `rs_val_i`. The next-next address becomes `rs_val_i`+4. If `comp_mode_i` is high, it instead raises `unsupported_o` and does not write a link. All three addresses are held.
- R8: With `link_i` high, a branch (taken or not) or an absolute jump writes the pre-update next-next address to index 31. A register jump writes it to `rd_idx_i`. For a step, exception return or debug return, `link_i` has no effect.
- R9: An exception return restarts without a delay slot at the return address A. The new addresses are A, A+4 and A+8. A is `err_ret_i` with `clr_err_lvl_o` raised when `err_lvl_i` is high. Otherwise A is `exc_ret_i` with `clr_exc_lvl_o` raised. `clr_llbit_o` is raised in both cases.
- R10: With `dbg_mode_i` high, a debug return restarts at `dbg_ret_i` in the same way as R9 and raises `clr_dbg_exc_o`. With `dbg_mode_i` low it holds all three addresses and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze the sequencer this cycle |
| cmd_i | input | 3 | Control-flow command code |
| taken_i | input | 1 | Branch condition result |
| likely_i | input | 1 | Branch is of the likely (slot-annulling) kind |
| link_i | input | 1 | Command also writes a return address |
| disp_i | input | 32 | Sign-extended byte displacement of a branch |
| jtarg_i | input | 26 | Word index of an absolute jump |
| rs_val_i | input | 32 | Register value for a register jump |
| rd_idx_i | input | 5 | Destination index for a register jump with link |
| comp_mode_i | input | 1 | Compressed-instruction mode is selected |
| err_lvl_i | input | 1 | Error-level status bit |
| dbg_mode_i | input | 1 | Debug mode status bit |
| exc_ret_i | input | 32 | Exception return address |
| err_ret_i | input | 32 | Error return address |
| dbg_ret_i | input | 32 | Debug return address |
| fetch_pc_o | output | 32 | Current fetch address |
| next_pc_o | output | 32 | Next address |
| next2_pc_o | output | 32 | Next-next address |
| link_we_o | output | 1 | Link write enable |
| link_idx_o | output | 5 | Link destination index |
| link_val_o | output | 32 | Link value |
| clr_err_lvl_o | output | 1 | Clear error-level bit |
| clr_exc_lvl_o | output | 1 | Clear exception-level bit |
| clr_llbit_o | output | 1 | Clear load-linked flag |
| clr_dbg_exc_o | output | 1 | Clear debug exception-in-progress bit |
| unsupported_o | output | 1 | Register jump refused in compressed mode |

## Verification
The properties assume that every input is known and stable at each rising edge. They also assume that the address operands (`disp_i`, `rs_val_i` and the three return addresses) are word multiples, so the sums they predict never depend on low-bit carries. The stimulus changes inputs only on the falling edge. It builds displacements from a signed 16-bit word offset shifted by two and masks every address operand to a multiple of 4. The random phase draws all eight command codes and every combination of `taken_i`, `likely_i`, `link_i`, `comp_mode_i`, `err_lvl_i` and `dbg_mode_i`, with occasional stalls and mid-run resets.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned REG_W  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [REG_W-1:0]  ridx_t;

    typedef enum logic [2:0] {
        CMD_STEP   = 3'd0,
        CMD_BRANCH = 3'd1,
        CMD_JABS   = 3'd2,
        CMD_JREG   = 3'd3,
        CMD_ERET   = 3'd4,
        CMD_DRET   = 3'd5,
        CMD_RSV6   = 3'd6,
        CMD_RSV7   = 3'd7
    } flow_cmd_e;

    typedef struct packed {
        addr_t cur;
        addr_t nxt;
        addr_t nxt2;
    } pc_trio_t;

    typedef struct packed {
        logic  we;
        ridx_t idx;
        addr_t val;
    } link_req_t;

    typedef struct packed {
        logic clr_err;
        logic clr_exc;
        logic clr_ll;
        logic clr_dbg;
        logic unsup;
    } stat_clr_t;

    // Restart with no delay slot: execution begins at a.
    function automatic pc_trio_t resume_at(addr_t a, addr_t stride);
        pc_trio_t t;
        t.cur  = a;
        t.nxt  = a + stride;
        t.nxt2 = a + stride + stride;
        return t;
    endfunction

    // Run the slot next, then continue at tgt.
    function automatic pc_trio_t redirect(addr_t slot, addr_t tgt, addr_t stride);
        pc_trio_t t;
        t.cur  = slot;
        t.nxt  = tgt;
        t.nxt2 = tgt + stride;
        return t;
    endfunction

endpackage

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
#(
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned JT_W       = 26,
    parameter int unsigned SEG_W      = 4
) (
    input  pc_trio_t          cur_i,
    input  flow_cmd_e         cmd_i,
    input  logic              taken_i,
    input  logic              likely_i,
    input  addr_t             disp_i,
    input  logic [JT_W-1:0]   jtarg_i,
    input  addr_t             rs_val_i,
    input  logic              comp_mode_i,
    input  logic              err_lvl_i,
    input  logic              dbg_mode_i,
    input  addr_t             exc_ret_i,
    input  addr_t             err_ret_i,
    input  addr_t             dbg_ret_i,
    output pc_trio_t          nxt_o
);

    localparam addr_t       IB = addr_t'(INSN_BYTES);
    localparam int unsigned SH = $clog2(INSN_BYTES);

    addr_t seg_bits;

    generate
        if (SEG_W == 0) begin : g_noseg
            assign seg_bits = '0;
        end else begin : g_seg
            localparam addr_t SEG_MASK = {{SEG_W{1'b1}}, {(ADDR_W-SEG_W){1'b0}}};
            assign seg_bits = cur_i.nxt & SEG_MASK;
        end
    endgenerate

    pc_trio_t stepped;
    pc_trio_t annulled;
    addr_t    br_tgt;
    addr_t    jabs_tgt;
    addr_t    ret_addr;

    always_comb begin
        stepped.cur  = cur_i.nxt;
        stepped.nxt  = cur_i.nxt2;
        stepped.nxt2 = cur_i.nxt2 + IB;
        annulled     = resume_at(cur_i.nxt2, IB);
        br_tgt       = cur_i.nxt + disp_i;
        jabs_tgt     = seg_bits | (addr_t'(jtarg_i) << SH);
        ret_addr     = err_lvl_i ? err_ret_i : exc_ret_i;

        nxt_o = stepped;
        case (cmd_i)
            CMD_BRANCH: begin
                if (taken_i)       nxt_o = redirect(cur_i.nxt, br_tgt, IB);
                else if (likely_i) nxt_o = annulled;
            end
            CMD_JABS: nxt_o = redirect(cur_i.nxt, jabs_tgt, IB);
            CMD_JREG: begin
                if (comp_mode_i) nxt_o = cur_i;
                else             nxt_o = redirect(cur_i.nxt, rs_val_i, IB);
            end
            CMD_ERET: nxt_o = resume_at(ret_addr, IB);
            CMD_DRET: begin
                if (dbg_mode_i) nxt_o = resume_at(dbg_ret_i, IB);
                else            nxt_o = cur_i;
            end
            default: nxt_o = stepped;
        endcase
    end

endmodule

// File: rtl/seq_side.sv
module seq_side
    import seq_pkg::*;
#(
    parameter ridx_t LINK_REG = 5'd31
) (
    input  logic       act_i,
    input  flow_cmd_e  cmd_i,
    input  logic       link_i,
    input  ridx_t      rd_idx_i,
    input  addr_t      nnpc_i,
    input  logic       comp_mode_i,
    input  logic       err_lvl_i,
    input  logic       dbg_mode_i,
    output link_req_t  link_o,
    output stat_clr_t  clr_o
);

    always_comb begin
        link_o = '0;
        clr_o  = '0;
        if (act_i) begin
            case (cmd_i)
                CMD_BRANCH, CMD_JABS: begin
                    if (link_i) begin
                        link_o.we  = 1'b1;
                        link_o.idx = LINK_REG;
                        link_o.val = nnpc_i;
                    end
                end
                CMD_JREG: begin
                    if (comp_mode_i) begin
                        clr_o.unsup = 1'b1;
                    end else if (link_i) begin
                        link_o.we  = 1'b1;
                        link_o.idx = rd_idx_i;
                        link_o.val = nnpc_i;
                    end
                end
                CMD_ERET: begin
                    clr_o.clr_ll = 1'b1;
                    if (err_lvl_i) clr_o.clr_err = 1'b1;
                    else           clr_o.clr_exc = 1'b1;
                end
                CMD_DRET: begin
                    if (dbg_mode_i) clr_o.clr_dbg = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/seq_state.sv
module seq_state
    import seq_pkg::*;
#(
    parameter addr_t       RESET_VEC  = 32'hBFC0_0000,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  pc_trio_t nxt_i,
    output pc_trio_t q_o
);

    localparam addr_t IB = addr_t'(INSN_BYTES);

    always_ff @(posedge clk) begin
        if (rst)         q_o <= resume_at(RESET_VEC, IB);
        else if (load_i) q_o <= nxt_i;
    end

endmodule

// File: rtl/dspc_seq.sv
module dspc_seq
    import seq_pkg::*;
#(
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned JT_W       = 26,
    parameter int unsigned SEG_W      = 4,
    parameter logic [4:0]  LINK_REG   = 5'd31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stall_i,
    input  logic [2:0]          cmd_i,
    input  logic                taken_i,
    input  logic                likely_i,
    input  logic                link_i,
    input  logic [ADDR_W-1:0]   disp_i,
    input  logic [JT_W-1:0]     jtarg_i,
    input  logic [ADDR_W-1:0]   rs_val_i,
    input  logic [REG_W-1:0]    rd_idx_i,
    input  logic                comp_mode_i,
    input  logic                err_lvl_i,
    input  logic                dbg_mode_i,
    input  logic [ADDR_W-1:0]   exc_ret_i,
    input  logic [ADDR_W-1:0]   err_ret_i,
    input  logic [ADDR_W-1:0]   dbg_ret_i,
    output logic [ADDR_W-1:0]   fetch_pc_o,
    output logic [ADDR_W-1:0]   next_pc_o,
    output logic [ADDR_W-1:0]   next2_pc_o,
    output logic                link_we_o,
    output logic [REG_W-1:0]    link_idx_o,
    output logic [ADDR_W-1:0]   link_val_o,
    output logic                clr_err_lvl_o,
    output logic                clr_exc_lvl_o,
    output logic                clr_llbit_o,
    output logic                clr_dbg_exc_o,
    output logic                unsupported_o
);

    flow_cmd_e cmd;
    pc_trio_t  state;
    pc_trio_t  upd;
    link_req_t lreq;
    stat_clr_t sclr;
    logic      act;

    assign cmd = flow_cmd_e'(cmd_i);
    assign act = !stall_i && !rst;

    seq_next #(
        .INSN_BYTES (INSN_BYTES),
        .JT_W       (JT_W),
        .SEG_W      (SEG_W)
    ) u_next (
        .cur_i       (state),
        .cmd_i       (cmd),
        .taken_i     (taken_i),
        .likely_i    (likely_i),
        .disp_i      (disp_i),
        .jtarg_i     (jtarg_i),
        .rs_val_i    (rs_val_i),
        .comp_mode_i (comp_mode_i),
        .err_lvl_i   (err_lvl_i),
        .dbg_mode_i  (dbg_mode_i),
        .exc_ret_i   (exc_ret_i),
        .err_ret_i   (err_ret_i),
        .dbg_ret_i   (dbg_ret_i),
        .nxt_o       (upd)
    );

    seq_side #(
        .LINK_REG (LINK_REG)
    ) u_side (
        .act_i       (act),
        .cmd_i       (cmd),
        .link_i      (link_i),
        .rd_idx_i    (rd_idx_i),
        .nnpc_i      (state.nxt2),
        .comp_mode_i (comp_mode_i),
        .err_lvl_i   (err_lvl_i),
        .dbg_mode_i  (dbg_mode_i),
        .link_o      (lreq),
        .clr_o       (sclr)
    );

    seq_state #(
        .RESET_VEC  (RESET_VEC),
        .INSN_BYTES (INSN_BYTES)
    ) u_state (
        .clk    (clk),
        .rst    (rst),
        .load_i (!stall_i),
        .nxt_i  (upd),
        .q_o    (state)
    );

    assign fetch_pc_o    = state.cur;
    assign next_pc_o     = state.nxt;
    assign next2_pc_o    = state.nxt2;
    assign link_we_o     = lreq.we;
    assign link_idx_o    = lreq.idx;
    assign link_val_o    = lreq.val;
    assign clr_err_lvl_o = sclr.clr_err;
    assign clr_exc_lvl_o = sclr.clr_exc;
    assign clr_llbit_o   = sclr.clr_ll;
    assign clr_dbg_exc_o = sclr.clr_dbg;
    assign unsupported_o = sclr.unsup;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter int unsigned INSN_BYTES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        stall_i,
    input logic [2:0]  cmd_i,
    input logic        taken_i,
    input logic        likely_i,
    input logic [31:0] disp_i,
    input logic        comp_mode_i,
    input logic        err_lvl_i,
    input logic        dbg_mode_i,
    input logic [31:0] exc_ret_i,
    input logic [31:0] err_ret_i,
    input logic [31:0] fetch_pc_o,
    input logic [31:0] next_pc_o,
    input logic [31:0] next2_pc_o,
    input logic        link_we_o,
    input logic [31:0] link_val_o,
    input logic        clr_err_lvl_o,
    input logic        clr_exc_lvl_o,
    input logic        clr_llbit_o,
    input logic        clr_dbg_exc_o,
    input logic        unsupported_o
);

    localparam logic [31:0] IB = 32'(INSN_BYTES);

    a_r1_reset_vector: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_pc_o == RESET_VEC) && (next_pc_o == RESET_VEC + IB)
                       && (next2_pc_o == RESET_VEC + IB + IB));

    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(fetch_pc_o) && $stable(next_pc_o) && $stable(next2_pc_o));

    a_r2_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        stall_i |-> !link_we_o && !clr_err_lvl_o && !clr_exc_lvl_o && !clr_llbit_o
                    && !clr_dbg_exc_o && !unsupported_o);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && (cmd_i == 3'd0 || cmd_i >= 3'd6)) |=>
            (fetch_pc_o == $past(next_pc_o)) && (next_pc_o == $past(next2_pc_o))
            && (next2_pc_o == $past(next2_pc_o) + IB));

    a_r4_taken_branch: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd1 && taken_i) |=>
            (fetch_pc_o == $past(next_pc_o)) && (next_pc_o == $past(next_pc_o + disp_i))
            && (next2_pc_o == next_pc_o + IB));

    a_r5_likely_annul: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd1 && !taken_i && likely_i) |=>
            (fetch_pc_o == $past(next2_pc_o)));

    a_r7_unsupported_flag: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd3 && comp_mode_i) |-> unsupported_o && !link_we_o);

    a_r7_unsupported_hold: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd3 && comp_mode_i) |=>
            $stable(fetch_pc_o) && $stable(next_pc_o) && $stable(next2_pc_o));

    a_r8_link_value: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == next2_pc_o));

    a_r9_level_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_err_lvl_o, clr_exc_lvl_o}));

    a_r9_eret_target: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd4) |=>
            (fetch_pc_o == $past(err_lvl_i ? err_ret_i : exc_ret_i)));

    a_r9_eret_llbit: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd4) |-> clr_llbit_o);

    a_r10_dret_ignored: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_i == 3'd5 && !dbg_mode_i) |=>
            $stable(fetch_pc_o) && $stable(next_pc_o) && $stable(next2_pc_o));

    a_r10_dret_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_i != 3'd5 || !dbg_mode_i) |-> !clr_dbg_exc_o);

endmodule

bind dspc_seq seq_chk #(
    .RESET_VEC  (RESET_VEC),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .stall_i       (stall_i),
    .cmd_i         (cmd_i),
    .taken_i       (taken_i),
    .likely_i      (likely_i),
    .disp_i        (disp_i),
    .comp_mode_i   (comp_mode_i),
    .err_lvl_i     (err_lvl_i),
    .dbg_mode_i    (dbg_mode_i),
    .exc_ret_i     (exc_ret_i),
    .err_ret_i     (err_ret_i),
    .fetch_pc_o    (fetch_pc_o),
    .next_pc_o     (next_pc_o),
    .next2_pc_o    (next2_pc_o),
    .link_we_o     (link_we_o),
    .link_val_o    (link_val_o),
    .clr_err_lvl_o (clr_err_lvl_o),
    .clr_exc_lvl_o (clr_exc_lvl_o),
    .clr_llbit_o   (clr_llbit_o),
    .clr_dbg_exc_o (clr_dbg_exc_o),
    .unsupported_o (unsupported_o)
);

// File: tb/sim_dspc_seq.sv
`timescale 1ns/1ps
module sim_dspc_seq;

    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst, stall_i, taken_i, likely_i, link_i;
    logic [2:0]  cmd_i;
    logic [31:0] disp_i, rs_val_i, exc_ret_i, err_ret_i, dbg_ret_i;
    logic [25:0] jtarg_i;
    logic [4:0]  rd_idx_i;
    logic        comp_mode_i, err_lvl_i, dbg_mode_i;
    logic [31:0] fetch_pc_o, next_pc_o, next2_pc_o, link_val_o;
    logic        link_we_o, clr_err_lvl_o, clr_exc_lvl_o, clr_llbit_o, clr_dbg_exc_o, unsupported_o;
    logic [4:0]  link_idx_o;

    always #5 clk = ~clk;

    dspc_seq #(.RESET_VEC(RV)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    logic [31:0] m_pc, m_npc, m_nnpc;
    logic [31:0] n_pc, n_npc, n_nnpc;
    bit          m_valid = 0;
    string       last_tag = "R1";
    logic        e_we, e_cerr, e_cexc, e_cll, e_cdbg, e_uns;
    logic [4:0]  e_idx;
    logic [31:0] e_val;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_next(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        n_pc = a; n_npc = b; n_nnpc = c;
    endtask

    task automatic model(output string tag);
        logic [31:0] t;
        e_we = 0; e_idx = 0; e_val = 0;
        e_cerr = 0; e_cexc = 0; e_cll = 0; e_cdbg = 0; e_uns = 0;
        set_next(m_npc, m_nnpc, m_nnpc + 4);
        tag = "R3";
        if (rst) begin
            set_next(RV, RV + 4, RV + 8); tag = "R1";
        end else if (stall_i) begin
            set_next(m_pc, m_npc, m_nnpc); tag = "R2";
        end else begin
            case (cmd_i)
                3'd1: begin
                    if (link_i) begin e_we = 1; e_idx = 31; e_val = m_nnpc; end
                    if (taken_i) begin
                        t = m_npc + disp_i; set_next(m_npc, t, t + 4); tag = "R4";
                    end else begin
                        tag = "R5";
                        if (likely_i) set_next(m_nnpc, m_nnpc + 4, m_nnpc + 8);
                    end
                end
                3'd2: begin
                    if (link_i) begin e_we = 1; e_idx = 31; e_val = m_nnpc; end
                    t = {m_npc[31:28], jtarg_i, 2'b00};
                    set_next(m_npc, t, t + 4); tag = "R6";
                end
                3'd3: begin
                    tag = "R7";
                    if (comp_mode_i) begin
                        e_uns = 1; set_next(m_pc, m_npc, m_nnpc);
                    end else begin
                        if (link_i) begin e_we = 1; e_idx = rd_idx_i; e_val = m_nnpc; end
                        set_next(m_npc, rs_val_i, rs_val_i + 4);
                    end
                end
                3'd4: begin
                    tag = "R9"; e_cll = 1;
                    t = err_lvl_i ? err_ret_i : exc_ret_i;
                    if (err_lvl_i) e_cerr = 1; else e_cexc = 1;
                    set_next(t, t + 4, t + 8);
                end
                3'd5: begin
                    tag = "R10";
                    if (dbg_mode_i) begin
                        e_cdbg = 1; set_next(dbg_ret_i, dbg_ret_i + 4, dbg_ret_i + 8);
                    end else set_next(m_pc, m_npc, m_nnpc);
                end
                default: ;
            endcase
        end
    endtask

    // Inputs are already driven (at a falling edge); check and advance one cycle.
    task automatic step();
        string tag;
        #1;
        if (m_valid) begin
            chk(last_tag, "fetch_pc", fetch_pc_o, m_pc);
            chk(last_tag, "next_pc", next_pc_o, m_npc);
            chk(last_tag, "next2_pc", next2_pc_o, m_nnpc);
            model(tag);
            chk("R8", "link_we", 32'(link_we_o), 32'(e_we));
            if (e_we) begin
                chk("R8", "link_idx", 32'(link_idx_o), 32'(e_idx));
                chk("R8", "link_val", link_val_o, e_val);
            end
            chk(tag, "clear strobes",
                32'({clr_err_lvl_o, clr_exc_lvl_o, clr_llbit_o, clr_dbg_exc_o, unsupported_o}),
                32'({e_cerr, e_cexc, e_cll, e_cdbg, e_uns}));
        end else begin
            model(tag);
        end
        @(posedge clk);
        m_pc = n_pc; m_npc = n_npc; m_nnpc = n_nnpc;
        if (tag == "R1") m_valid = 1;
        last_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; stall_i = 0; cmd_i = 0; taken_i = 0; likely_i = 0; link_i = 0;
        disp_i = 0; jtarg_i = 0; rs_val_i = 0; rd_idx_i = 0;
        comp_mode_i = 0; err_lvl_i = 0; dbg_mode_i = 0;
        exc_ret_i = 32'h8000_0180; err_ret_i = 32'h8000_0400; dbg_ret_i = 32'hFF20_0200;
    endtask

    function automatic logic [31:0] rnd_addr();
        return $urandom() & 32'hFFFF_FFFC;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        repeat (3) step();                                   // R1 reset
        rst = 0;
        chk("R1", "reset fetch", fetch_pc_o, RV);
        chk("R1", "reset next2", next2_pc_o, RV + 8);
        step(); step();                                      // R3 steps
        cmd_i = 1; taken_i = 1; link_i = 1; disp_i = 32'd16; step();        // R4 + R8
        idle(); cmd_i = 1; taken_i = 1; disp_i = 32'hFFFF_FFE0; step();     // R4 backward
        idle(); cmd_i = 1; step();                                           // R5 normal
        idle(); cmd_i = 1; likely_i = 1; link_i = 1; step();                 // R5 likely, R8
        idle(); cmd_i = 2; jtarg_i = 26'h123_4567; step();                   // R6
        idle(); cmd_i = 3; comp_mode_i = 1; link_i = 1; rs_val_i = 32'h1000; step(); // R7
        idle(); cmd_i = 3; link_i = 1; rd_idx_i = 5'd7; rs_val_i = 32'h0040_0020; step(); // R7 R8
        idle(); cmd_i = 4; err_lvl_i = 1; step();                            // R9 error
        idle(); cmd_i = 4; link_i = 1; step();                               // R9, R8 ignored
        idle(); cmd_i = 5; step();                                           // R10 ignored
        idle(); cmd_i = 5; dbg_mode_i = 1; step();                           // R10 taken
        idle(); stall_i = 1; cmd_i = 2; link_i = 1; step();                  // R2
        idle(); cmd_i = 6; step(); cmd_i = 7; step();                        // R3 reserved
        idle(); link_i = 1; step();                                          // R8 step ignores link
        idle(); step();

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] off;
            off = 16'($urandom());
            rst         = ($urandom_range(199, 0) == 0);
            stall_i     = ($urandom_range(9, 0) == 0);
            cmd_i       = 3'($urandom_range(7, 0));
            taken_i     = 1'($urandom());
            likely_i    = 1'($urandom());
            link_i      = 1'($urandom());
            comp_mode_i = ($urandom_range(3, 0) == 0);
            err_lvl_i   = 1'($urandom());
            dbg_mode_i  = 1'($urandom());
            disp_i      = {{14{off[15]}}, off, 2'b00};
            jtarg_i     = 26'($urandom());
            rs_val_i    = rnd_addr();
            rd_idx_i    = 5'($urandom());
            exc_ret_i   = rnd_addr();
            err_ret_i   = rnd_addr();
            dbg_ret_i   = rnd_addr();
            step();
        end
        idle();
        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule